// File: doc/BRIEF.md
# Tachometer Period Capture Timer

This block measures the interval between successive rising edges of an asynchronous tachometer pulse. A free-running up-counter runs on the single timer clock. When a synchronized rising edge is seen, the counter value is copied into a capture register and the counter restarts from zero in the same clock. The next interval is therefore timed at once, with no software involvement for each edge.

If no edge arrives, the counter wraps at its all-ones value and raises a sticky overflow indication. The capture register and both sticky flags keep their values across every reload. A slow periodic routine, running about once per millisecond, collects them through a small register read port. Reading the status word clears the flags. Reading the capture word clears nothing.

The read port is a plain request/response port, not a stream. `rd_en` asks for one word. The word appears on `rd_data` with `rd_valid` high exactly one clock later. There is no back-pressure, and a request is accepted in every cycle.

Top module: `tach_period_timer`

## Requirements
- R1: `tach_in` passes through a two-stage synchronizer. A rising edge is recognized when the synchronized sample is 1 and the previous synchronized sample was 0. A falling edge, or a steady level, causes no capture and does not set the new-capture flag.
- R2: The counter starts from 0 and increases by exactly one on every clock that has neither a capture nor a terminal count. It can be read live at address 2.
- R3: When the counter holds all ones (2^CNT_W−1) and no capture occurs, it reloads to 0 on the next clock and sets the sticky overflow flag.
- R4: A recognized rising edge copies the current count into the capture register and reloads the counter to 0 in the same clock. For two rises of `tach_in` that are N clocks apart, the captured value is N−1.
- R5: A reload, whether from a capture or from terminal count, never clears the capture register or either flag. The capture register changes only on a capture.
- R6: Each capture sets a sticky new-capture flag, which stays set until the status word is read.
- R7: A read of the status word (address 1) clears both sticky flags after returning their values. A read of the capture word (address 0) leaves both flags and the capture register unchanged.
- R8: If a capture and a terminal count fall in the same clock, the capture is taken: the all-ones count is stored, the counter reloads to 0, and the overflow flag is also set.
- R9: An active-high synchronous reset clears the counter, the capture register, both flags and the synchronizer.
- R10: `rd_data` and `rd_valid` are registered one clock after `rd_en`. Address 0 is the capture register. Address 1 is the status word, with bit 0 the new-capture flag, bit 1 the overflow flag, and all other bits 0. Address 2 is the live count. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Active-high synchronous reset |
| tach_in | input | 1 | Asynchronous tachometer pulse |
| rd_en | input | 1 | Read request, one word per cycle |
| rd_addr | input | 2 | Word select: 0 capture, 1 status, 2 count, 3 zero |
| rd_data | output | CNT_W | Read word, valid when rd_valid is high |
| rd_valid | output | 1 | High one clock after rd_en |

## Verification
A counter that skips or stalls shows up in the very next capture as an interval that is off by the missing clocks. It also shows up in two live-count reads a known distance apart. A reload path that disturbs the capture register or the flags shows up at the first read after an overflow, which then returns a changed capture or lost flags. Flag-clearing faults appear at the second status read, a single clock after the first. A wrong priority between capture and terminal count shows up as a zero capture or a missing overflow bit in the exact-wrap test.

// File: rtl/tach_pkg.sv
package tach_pkg;
  typedef enum logic [1:0] {
    SEL_CAPTURE = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_COUNT   = 2'd2,
    SEL_NONE    = 2'd3
  } rd_sel_e;

  localparam int STAT_NEW_BIT = 0;
  localparam int STAT_OVF_BIT = 1;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign rise_o = chain_q[LAST] & ~prev_q;

  // R1: a recognized edge lasts exactly one clock
  p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tach_free_counter.sv
module tach_free_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_q;

  assign tc_o    = (cnt_q == ALL_ONES);
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (reload_i || tc_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + W'(1);
  end

  // R2: plain increment when nothing reloads
  p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
    (!reload_i && !tc_o) |=> (cnt_q == $past(cnt_q) + W'(1)));
  // R3: wrap at all ones
  p_tc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> (cnt_q == '0));
  // R4: capture restarts the count
  p_reload_zero_r4: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (cnt_q == '0));
endmodule

// File: rtl/tach_capture_bank.sv
module tach_capture_bank
  import tach_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_evt_i,
  input  logic         tc_i,
  input  logic [W-1:0] count_i,
  input  logic         rd_en_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o
);
  logic [W-1:0] cap_q;
  logic         new_q;
  logic         ovf_q;
  logic         stat_clr;
  logic [W-1:0] rd_mux;
  rd_sel_e      sel;

  assign sel      = rd_sel_e'(rd_addr_i);
  assign stat_clr = rd_en_i && (sel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst)            cap_q <= '0;
    else if (cap_evt_i) cap_q <= count_i;
  end

  // a set in the same clock as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (rst) begin
      new_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      new_q <= cap_evt_i | (new_q & ~stat_clr);
      ovf_q <= tc_i      | (ovf_q & ~stat_clr);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CAPTURE: rd_mux = cap_q;
      SEL_STATUS: begin
        rd_mux[STAT_NEW_BIT] = new_q;
        rd_mux[STAT_OVF_BIT] = ovf_q;
      end
      SEL_COUNT:   rd_mux = count_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  // R4: capture stores the running count
  p_cap_load_r4: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> (cap_q == $past(count_i)));
  // R5: capture register changes only on a capture
  p_cap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cap_evt_i |=> $stable(cap_q));
  // R6: capture marks the new flag
  p_new_set_r6: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> new_q);
  // R8: terminal count marks overflow, also alongside a capture
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    tc_i |=> ovf_q);
  // R7: flags fall only through a status read
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(new_q) || $fell(ovf_q)) |-> $past(stat_clr));
  // R10: one-clock read response
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
endmodule

// File: rtl/tach_period_timer.sv
module tach_period_timer #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tach_in,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid
);
  logic             rise;
  logic             tc;
  logic [CNT_W-1:0] count;

  tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (tach_in),
    .rise_o   (rise)
  );

  tach_free_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .reload_i (rise),
    .count_o  (count),
    .tc_o     (tc)
  );

  tach_capture_bank #(.W(CNT_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cap_evt_i  (rise),
    .tc_i       (tc),
    .count_i    (count),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid)
  );

  // R9: reset leaves the read port idle
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> !rd_valid);
endmodule

// File: tb/tach_period_timer_tb_top.sv
module tach_period_timer_tb_top;
  localparam int W = 12;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tach_in = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = 2'd0;
  logic [W-1:0] rd_data;
  logic         rd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tach_period_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .tach_in(tach_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one read, exactly one clock long: request at a falling edge, sample at the next
  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    checks++;
    if (rd_valid !== 1'b1) begin
      failures++;
      $display("FAIL R10 actual=%0d expected=1 (rd_valid)", rd_valid);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tach_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    do_reset();
    rd(2'd0, v); check("R9 capture after reset", v, '0);
    rd(2'd1, v); check("R9 status after reset", v, '0);
    rd(2'd3, v); check("R10 unused address", v, '0);
  endtask

  task automatic t_count();
    logic [W-1:0] a, b;
    do_reset();
    rd(2'd2, a);
    idle(9);
    rd(2'd2, b);
    check("R2 live count advance", b - a, W'(10));
  endtask

  task automatic t_period();
    logic [W-1:0] v;
    do_reset();
    tach_in = 1'b1; idle(20); tach_in = 1'b0; idle(80);
    tach_in = 1'b1; idle(10); tach_in = 1'b0; idle(27);
    tach_in = 1'b1; idle(5);
    rd(2'd0, v); check("R4 interval 37", v, W'(36));
    rd(2'd1, v); check("R6 new flag set", v, W'(1));
    tach_in = 1'b0;
    idle(8);
    rd(2'd1, v); check("R1 falling edge ignored", v, W'(0));
    rd(2'd0, v); check("R1 capture kept after fall", v, W'(36));
  endtask

  task automatic t_overflow();
    logic [W-1:0] v;
    do_reset();
    tach_in = 1'b1; idle(10); tach_in = 1'b0; idle(40);
    tach_in = 1'b1; idle(5); tach_in = 1'b0;
    idle(4500);
    rd(2'd0, v); check("R5 capture survives wrap", v, W'(49));
    rd(2'd0, v); check("R7 capture read keeps capture", v, W'(49));
    rd(2'd1, v); check("R3 overflow and new flags", v, W'(3));
    rd(2'd1, v); check("R7 status read clears", v, W'(0));
    rd(2'd2, v);
    checks++;
    if (v >= W'(4000)) begin
      failures++;
      $display("FAIL R3 actual=%0d expected<4000 (count after wrap)", v);
    end
  endtask

  task automatic t_coincide();
    logic [W-1:0] v;
    do_reset();
    tach_in = 1'b1;
    rd(2'd1, v);
    tach_in = 1'b0;
    idle(4095);
    tach_in = 1'b1;
    idle(5);
    rd(2'd0, v); check("R8 all-ones captured", v, MAXV);
    rd(2'd1, v); check("R8 overflow with capture", v, W'(3));
    rd(2'd2, v);
    checks++;
    if (v > W'(12)) begin
      failures++;
      $display("FAIL R4 actual=%0d expected<=12 (count after capture reload)", v);
    end
  endtask

  task automatic t_reset_mid();
    logic [W-1:0] v;
    tach_in = 1'b1; idle(6);
    do_reset();
    rd(2'd0, v); check("R9 capture cleared mid-run", v, '0);
    rd(2'd1, v); check("R9 flags cleared mid-run", v, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_period();
    t_overflow();
    t_coincide();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule